// File: doc/BRIEF.md
# Pipelined Partial-Sum Table Builder

This block keeps a window of the four most recent input samples and, from them, builds the fifteen non-zero subset sums that a bit-serial inner-product stage needs. The selector that picks one of these sums on each bit cycle is not part of this block. Entry `m` of the table is the sum of every sample whose bit is set in the 4-bit mask `m`.

Only seven adders are built. Each accepted sample shifts the window and starts a fill. The first fill step forms all six pair sums. The second step forms the four three-sample sums from stored pairs plus one sample. The third step forms the four-sample sum from a stored triple plus one sample. The one-sample entries are the window registers themselves, so the table holds exactly fifteen registers.

Samples arrive on a valid/ready stream. The input is never back-pressured outside reset. A sample that arrives while a fill is running is taken at once, and the fill starts again on the new window. A consumer waits for the table-valid flag before it reads the table.

Top module: `da_partial_table`

## Requirements
- R1: While reset is high at a rising edge, the next cycle shows `tbl_valid_o` low and all 15 table entries zero.
- R2: `s_ready_o` is low during reset and high at all other times. A sample is accepted on every rising edge where `s_valid_i` and `s_ready_o` are both high.
- R3: After an accepting edge, the entry for mask 1<<i holds the sample accepted i acceptances earlier (i=0 is the newest), sign-extended to the entry width.
- R4: Each entry is SAMPLE_W+2 bits in two's complement. Entry m is the exact sum of the samples whose bits are set in m, and no four-sample sum can overflow. Entry m sits at bits [m*EW-1 : (m-1)*EW] of `tbl_o`, where EW = SAMPLE_W+2.
- R5: When a sample is accepted and no further sample follows, `tbl_valid_o` is high after the third rising edge following the accepting edge. At that point every entry matches the new window.
- R6: `tbl_valid_o` goes low on every accepting edge. A sample accepted during a fill restarts the fill, and R5 then counts from the latest acceptance.
- R7: While `tbl_valid_o` is high and no sample is accepted, all table entries and the flag stay unchanged, whatever the value on `s_data_i`.
- R8: The fill order is fixed. The pair entries (masks 3,5,6,9,10,12) are updated on the first edge after acceptance. The triple entries (7,11,13,14) are updated on the second edge. Entry 15 is updated on the third edge. Until its step arrives, an entry keeps its value from the previous window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| s_valid_i | input | 1 | Input sample present |
| s_ready_o | output | 1 | Block can take a sample (high outside reset) |
| s_data_i | input | SAMPLE_W | Two's-complement input sample |
| tbl_o | output | 15*(SAMPLE_W+2) | Flattened table, entry m at slot m-1 |
| tbl_valid_o | output | 1 | Every entry reflects the current window |

## Verification
The hardest state to reach from the ports is the middle of a fill. In that state some entries already belong to the new window and the rest still hold the previous one. The bench reaches it by pushing one sample and sampling the table after each of the three fill edges. It compares the pair, triple and full-sum entries against both the new window and the old window it keeps. It also pushes a second sample one cycle into a fill, and pushes samples on back-to-back cycles, to show that a fill can be interrupted and restarted. Two full sweeps over all 256 sample values, in order and in a scattered order, together with saturated windows at both extremes, cover the guard bits.

// File: rtl/da_tbl_pkg.sv
package da_tbl_pkg;

  localparam int NUM_TAPS   = 4;
  localparam int NUM_SLOTS  = (1 << NUM_TAPS) - 1;
  localparam int NUM_ADDERS = 7;
  localparam int GUARD_W    = $clog2(NUM_TAPS);
  localparam int MASK_W     = NUM_TAPS;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_PAIR   = 2'd1,
    PH_TRIPLE = 2'd2,
    PH_QUAD   = 2'd3
  } fill_phase_e;

  // One adder operation: two source masks and a destination mask (0 = idle).
  typedef struct packed {
    logic [MASK_W-1:0] opa;
    logic [MASK_W-1:0] opb;
    logic [MASK_W-1:0] dst;
  } add_op_t;

  function automatic int unsigned popcnt(int unsigned m);
    int unsigned c = 0;
    for (int b = 0; b < NUM_TAPS; b++) c += (m >> b) & 1;
    return c;
  endfunction

  // Operand routing for each adder in each fill phase.
  function automatic add_op_t sched(int k, fill_phase_e ph);
    add_op_t o;
    o = '0;
    case (ph)
      PH_PAIR: begin
        case (k)
          0: o = '{4'd1, 4'd2, 4'd3};
          1: o = '{4'd2, 4'd4, 4'd6};
          2: o = '{4'd4, 4'd8, 4'd12};
          3: o = '{4'd1, 4'd4, 4'd5};
          4: o = '{4'd2, 4'd8, 4'd10};
          5: o = '{4'd1, 4'd8, 4'd9};
          default: o = '0;
        endcase
      end
      PH_TRIPLE: begin
        case (k)
          0: o = '{4'd3,  4'd4, 4'd7};
          1: o = '{4'd6,  4'd8, 4'd14};
          2: o = '{4'd12, 4'd1, 4'd13};
          3: o = '{4'd3,  4'd8, 4'd11};
          default: o = '0;
        endcase
      end
      PH_QUAD: begin
        if (k == 6) o = '{4'd14, 4'd1, 4'd15};
      end
      default: o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/da_tap_line.sv
module da_tap_line
  import da_tbl_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                shift_i,
  input  logic [SAMPLE_W-1:0] din_i,
  output logic [SAMPLE_W-1:0] taps_o [NUM_TAPS]
);

  logic [SAMPLE_W-1:0] tap_q [NUM_TAPS];

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        tap_q[t] <= '0;
      end else if (shift_i) begin
        if (t == 0) tap_q[t] <= din_i;
        else        tap_q[t] <= tap_q[t-1];
      end
    end
    assign taps_o[t] = tap_q[t];
  end

endmodule

// File: rtl/da_fill_seq.sv
module da_fill_seq
  import da_tbl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        start_i,
  output fill_phase_e phase_o,
  output logic        done_o
);

  fill_phase_e phase_q;
  logic        done_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_PAIR;
      done_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_PAIR:   phase_q <= PH_TRIPLE;
        PH_TRIPLE: phase_q <= PH_QUAD;
        PH_QUAD: begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;

endmodule

// File: rtl/da_adder_bank.sv
module da_adder_bank
  import da_tbl_pkg::*;
#(
  parameter int ENTRY_W = 10
) (
  input  fill_phase_e       phase_i,
  input  logic [ENTRY_W-1:0] view_i [NUM_SLOTS+1],
  output logic [ENTRY_W-1:0] sum_o  [NUM_ADDERS],
  output logic [MASK_W-1:0]  dst_o  [NUM_ADDERS]
);

  for (genvar k = 0; k < NUM_ADDERS; k++) begin : g_add
    add_op_t op;
    assign op       = sched(k, phase_i);
    assign sum_o[k] = view_i[op.opa] + view_i[op.opb];
    assign dst_o[k] = op.dst;
  end

endmodule

// File: rtl/da_partial_table.sv
module da_partial_table
  import da_tbl_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                                     clk_i,
  input  logic                                     rst_i,
  input  logic                                     s_valid_i,
  output logic                                     s_ready_o,
  input  logic [SAMPLE_W-1:0]                      s_data_i,
  output logic [NUM_SLOTS*(SAMPLE_W+GUARD_W)-1:0]  tbl_o,
  output logic                                     tbl_valid_o
);

  localparam int ENTRY_W = SAMPLE_W + GUARD_W;

  logic                accept;
  logic [SAMPLE_W-1:0] taps [NUM_TAPS];
  fill_phase_e         phase;
  logic [ENTRY_W-1:0]  view [NUM_SLOTS+1];
  logic [ENTRY_W-1:0]  add_sum [NUM_ADDERS];
  logic [MASK_W-1:0]   add_dst [NUM_ADDERS];

  assign s_ready_o = ~rst_i;
  assign accept    = s_valid_i & s_ready_o;

  da_tap_line #(.SAMPLE_W(SAMPLE_W)) u_taps (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .shift_i (accept),
    .din_i   (s_data_i),
    .taps_o  (taps)
  );

  da_fill_seq u_seq (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (accept),
    .phase_o (phase),
    .done_o  (tbl_valid_o)
  );

  da_adder_bank #(.ENTRY_W(ENTRY_W)) u_bank (
    .phase_i (phase),
    .view_i  (view),
    .sum_o   (add_sum),
    .dst_o   (add_dst)
  );

  assign view[0] = '0;

  for (genvar m = 1; m <= NUM_SLOTS; m++) begin : g_slot
    if (popcnt(m) == 1) begin : g_single
      localparam int TI = $clog2(m);
      assign view[m] = {{GUARD_W{taps[TI][SAMPLE_W-1]}}, taps[TI]};
    end else begin : g_sum
      logic [ENTRY_W-1:0] slot_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          slot_q <= '0;
        end else begin
          for (int k = 0; k < NUM_ADDERS; k++) begin
            if (add_dst[k] == MASK_W'(m)) slot_q <= add_sum[k];
          end
        end
      end
      assign view[m] = slot_q;
    end
    assign tbl_o[m*ENTRY_W-1 -: ENTRY_W] = view[m];
  end

endmodule

// File: rtl/da_partial_table_chk.sv
module da_partial_table_chk
  import da_tbl_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input logic                                    clk_i,
  input logic                                    rst_i,
  input logic                                    s_valid_i,
  input logic                                    s_ready_o,
  input logic [SAMPLE_W-1:0]                     s_data_i,
  input logic [NUM_SLOTS*(SAMPLE_W+GUARD_W)-1:0] tbl_o,
  input logic                                    tbl_valid_o
);

  localparam int EW = SAMPLE_W + GUARD_W;

  logic          acc;
  logic [2:0]    acc_hist;
  logic [EW-1:0] slot [1:NUM_SLOTS];

  assign acc = s_valid_i & s_ready_o;

  for (genvar m = 1; m <= NUM_SLOTS; m++) begin : g_view
    assign slot[m] = tbl_o[m*EW-1 -: EW];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) acc_hist <= '0;
    else       acc_hist <= {acc_hist[1:0], acc};
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (!tbl_valid_o && tbl_o == '0));

  // R3
  a_r3_newest_tap: assert property (@(posedge clk_i) disable iff (rst_i)
    acc |=> slot[1] == {{GUARD_W{$past(s_data_i[SAMPLE_W-1])}}, $past(s_data_i)});

  // R4
  a_r4_pair_sum: assert property (@(posedge clk_i) disable iff (rst_i)
    tbl_valid_o |-> slot[3] == EW'(slot[1] + slot[2]));

  a_r4_full_sum: assert property (@(posedge clk_i) disable iff (rst_i)
    tbl_valid_o |-> slot[15] == EW'(slot[1] + slot[2] + slot[4] + slot[8]));

  // R5
  a_r5_fill_done: assert property (@(posedge clk_i) disable iff (rst_i)
    (acc_hist == 3'b100 && !acc) |=> tbl_valid_o);

  // R6
  a_r6_accept_drops_valid: assert property (@(posedge clk_i) disable iff (rst_i)
    acc |=> !tbl_valid_o);

  // R7
  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    (tbl_valid_o && !acc) |=> ($stable(tbl_o) && tbl_valid_o));

endmodule

bind da_partial_table da_partial_table_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/da_partial_table_tb_top.sv
module da_partial_table_tb_top;

  localparam int SW = 8;
  localparam int EW = SW + 2;

  logic             clk = 1'b0;
  logic             rst;
  logic             s_valid;
  logic             s_ready;
  logic [SW-1:0]    s_data;
  logic [15*EW-1:0] tbl;
  logic             tbl_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int win  [4];
  int prev [4];

  always #2.5 clk = ~clk;

  da_partial_table #(.SAMPLE_W(SW)) dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .s_valid_i   (s_valid),
    .s_ready_o   (s_ready),
    .s_data_i    (s_data),
    .tbl_o       (tbl),
    .tbl_valid_o (tbl_valid)
  );

  function automatic int slot_val(int m);
    logic [EW-1:0] r;
    r = tbl[m*EW-1 -: EW];
    return int'($signed(r));
  endfunction

  function automatic int exp_of(int m, bit use_prev);
    int s = 0;
    for (int i = 0; i < 4; i++)
      if ((m >> i) & 1) s += use_prev ? prev[i] : win[i];
    return s;
  endfunction

  task automatic chk(string req, int act, int expv, string what);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Compare every mask whose population count is in [lo,hi] against a window.
  task automatic chk_group(string req, int lo, int hi, bit use_prev);
    for (int m = 1; m < 16; m++) begin
      int pc = $countones(m[3:0]);
      if (pc >= lo && pc <= hi)
        chk(req, slot_val(m), exp_of(m, use_prev), $sformatf("entry %0d", m));
    end
  endtask

  // Drive one sample at a negedge; returns at the negedge after the accepting edge.
  task automatic push(int v);
    s_valid = 1'b1;
    s_data  = SW'(v);
    @(negedge clk);
    s_valid = 1'b0;
    for (int i = 0; i < 4; i++) prev[i] = win[i];
    for (int i = 3; i > 0; i--) win[i] = win[i-1];
    win[0] = int'($signed(SW'(v)));
  endtask

  // Push a sample and check every fill step (R3, R6, R8, R5, R4).
  task automatic push_and_track(int v);
    push(v);
    chk("R6", int'(tbl_valid), 0, "valid after accept");
    chk_group("R3", 1, 1, 1'b0);
    @(negedge clk);
    chk_group("R8", 2, 2, 1'b0);
    chk_group("R8", 4, 4, 1'b1);
    @(negedge clk);
    chk_group("R8", 3, 3, 1'b0);
    chk_group("R8", 4, 4, 1'b1);
    chk("R5", int'(tbl_valid), 0, "valid before last step");
    @(negedge clk);
    chk("R5", int'(tbl_valid), 1, "valid after fill");
    chk_group("R4", 1, 4, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    s_valid = 1'b1;
    s_data = 8'h55;
    for (int i = 0; i < 4; i++) begin win[i] = 0; prev[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R2", int'(s_ready), 0, "ready in reset");
    s_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", int'(tbl_valid), 0, "valid after reset");
    chk_group("R1", 1, 4, 1'b0);
    @(negedge clk);
    chk("R2", int'(s_ready), 1, "ready after reset");

    // Sweep in order over every sample value.
    for (int v = -128; v < 128; v++) push_and_track(v);
    // Scattered order over every value.
    for (int v = 0; v < 256; v++) push_and_track(((v * 73) + 11) & 255);

    // Saturated windows at both extremes (guard bits, R4).
    for (int i = 0; i < 4; i++) push_and_track(-128);
    chk("R4", slot_val(15), -512, "all-min full sum");
    for (int i = 0; i < 4; i++) push_and_track(127);
    chk("R4", slot_val(15), 508, "all-max full sum");

    // Restart one cycle into a fill (R6).
    push(17);
    @(negedge clk);
    push(-45);
    chk("R6", int'(tbl_valid), 0, "valid after restart accept");
    @(negedge clk);
    chk("R6", int'(tbl_valid), 0, "valid restart +1");
    @(negedge clk);
    chk("R6", int'(tbl_valid), 0, "valid restart +2");
    @(negedge clk);
    chk("R6", int'(tbl_valid), 1, "valid restart +3");
    chk_group("R6", 1, 4, 1'b0);

    // Back-to-back samples on consecutive cycles (R2, R6).
    for (int i = 0; i < 6; i++) begin
      push(i * 29 - 70);
      chk("R6", int'(tbl_valid), 0, "valid during burst");
    end
    repeat (3) @(negedge clk);
    chk("R6", int'(tbl_valid), 1, "valid after burst");
    chk_group("R2", 1, 4, 1'b0);

    // Idle hold with wandering data and valid low (R7).
    for (int c = 0; c < 8; c++) begin
      s_data = SW'(c * 37);
      @(negedge clk);
      chk("R7", int'(tbl_valid), 1, "valid held");
    end
    chk_group("R7", 1, 4, 1'b0);

    // Reset again from a filled table (R1).
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) win[i] = 0;
    chk("R1", int'(tbl_valid), 0, "valid after second reset");
    chk_group("R1", 1, 4, 1'b0);

    summary();
    $finish;
  end

endmodule